// File: doc/BRIEF.md
# SECDED Storage Word Codec

This block protects a data word that goes into storage and comes back out. It uses a single-error-correcting, double-error-detecting Hamming code. The encoder side is purely combinational. It takes a data word and produces a code word. In that code word, check bits sit at the power-of-two positions of a 1-based position numbering. Data bits fill the other positions in ascending order. A final bit makes the parity of the whole word even.

The decoder side registers its results with one cycle of latency. It computes a syndrome from the Hamming positions and the parity of the full received word. A syndrome that names a valid position is corrected by flipping that bit. The decoder then reports a clean word, a corrected single error, or an uncorrectable error. On an uncorrectable error the data is passed through unmodified.

The data width `DW` is a parameter, with 8 as the default. The number of check bits `PW` is the smallest p with 2^p >= p + DW + 1. This gives 4 for 8 data bits, so the default code word is 13 bits wide.

Top module: `secded_codec`

## Requirements
- R1: Bit j of a code word holds position j+1. Positions 1, 2, 4 and 8 (with more powers of two for wider words) hold check bits. The remaining positions up to DW+PW hold data bits 0..DW-1 in ascending order. For DW=8 the data sits at positions 3, 5, 6, 7, 9, 10, 11 and 12.
- R2: The check bit at position 2^i gives even parity over all Hamming positions whose index has bit i set.
- R3: The top code word bit (index DW+PW) makes the parity of the whole code word even.
- R4: `dec_valid_o` equals `dec_valid_i` delayed by one clock. The decoded data and flags for a word appear in that same cycle. After reset `dec_valid_o`, `dec_single_o` and `dec_double_o` are 0.
- R5: A valid code word decodes to its data with both flags low.
- R6: A word with exactly one flipped bit among positions 1..DW+PW decodes to the original data, with `dec_single_o`=1 and `dec_double_o`=0.
- R7: A word whose only flipped bit is the overall parity bit decodes to the original data with `dec_single_o`=1.
- R8: A word with two flipped bits gives `dec_double_o`=1 and `dec_single_o`=0. The data output is the data bits read uncorrected from the received word.
- R9: A nonzero syndrome greater than DW+PW together with odd overall parity is reported as uncorrectable. In that case `dec_double_o`=1 and the data is passed through uncorrected.
- R10: Both flags are 0 in any cycle where `dec_valid_o` is 0, and the two flags are never 1 together.
- R11: With DW=4 the code word is 8 bits wide. The received word 8'hBF, which has syndrome 7, decodes to data 4'hF as a single error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_data_i | input | DW | Data word to encode |
| enc_code_o | output | DW+PW+1 | Encoded word, combinational |
| dec_valid_i | input | 1 | Received word is valid this cycle |
| dec_code_i | input | DW+PW+1 | Received code word |
| dec_valid_o | output | 1 | Decoded result valid |
| dec_data_o | output | DW | Corrected (or passed-through) data |
| dec_single_o | output | 1 | A single error was corrected |
| dec_double_o | output | 1 | An uncorrectable error was seen |

## Verification
A wrong syndrome bit or a wrong group assignment shows up in the cycle right after the word is presented. The data bit in that group comes out flipped, or the flags classify a clean or single-error word wrongly. The bench flips every Hamming position and the overall bit one at a time, so any miswired group is exposed. A wrong position-to-data mapping in the encoder is visible at once on `enc_code_o`. A fault in the overflow-syndrome path only appears for a triple flip that aims beyond position 12, which is why such a word is sent on purpose.

// File: rtl/secded_codec.sv
module secded_codec #(
  parameter int DW = 8,
  localparam int PW = $clog2(DW + $clog2(DW + 1) + 1),
  localparam int HW = DW + PW,
  localparam int CW = HW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] enc_data_i,
  output logic [CW-1:0] enc_code_o,
  input  logic          dec_valid_i,
  input  logic [CW-1:0] dec_code_i,
  output logic          dec_valid_o,
  output logic [DW-1:0] dec_data_o,
  output logic          dec_single_o,
  output logic          dec_double_o
);

  logic [HW:1] enc_h;

  always_comb begin
    int  k;
    logic b;
    k = 0;
    enc_h = '0;
    for (int pos = 1; pos <= HW; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        enc_h[pos] = enc_data_i[k];
        k++;
      end
    end
    for (int i = 0; i < PW; i++) begin
      b = 1'b0;
      for (int pos = 1; pos <= HW; pos++)
        if (pos[i]) b ^= enc_h[pos];
      enc_h[1 << i] = b;
    end
  end

  assign enc_code_o = {^enc_h, enc_h};

  logic [HW:1]   rx_h, fix_h;
  logic [PW-1:0] syn;
  logic          ovp, syn_nz, syn_in, single_c, double_c;
  logic [DW-1:0] raw_d, fix_d;

  assign rx_h = dec_code_i[HW-1:0];
  assign ovp  = ^dec_code_i;

  always_comb begin
    syn = '0;
    for (int i = 0; i < PW; i++)
      for (int pos = 1; pos <= HW; pos++)
        if (pos[i]) syn[i] ^= rx_h[pos];
  end

  assign syn_nz   = (syn != '0);
  assign syn_in   = (int'(syn) <= HW);
  assign single_c = ovp && (!syn_nz || syn_in);
  assign double_c = syn_nz && (!ovp || !syn_in);

  always_comb begin
    int k;
    k = 0;
    raw_d = '0;
    fix_d = '0;
    for (int pos = 1; pos <= HW; pos++)
      fix_h[pos] = rx_h[pos] ^ (single_c && (int'(syn) == pos));
    for (int pos = 1; pos <= HW; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        raw_d[k] = rx_h[pos];
        fix_d[k] = fix_h[pos];
        k++;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_o  <= 1'b0;
      dec_single_o <= 1'b0;
      dec_double_o <= 1'b0;
      dec_data_o   <= '0;
    end else begin
      dec_valid_o  <= dec_valid_i;
      dec_single_o <= dec_valid_i && single_c;
      dec_double_o <= dec_valid_i && double_c;
      if (dec_valid_i) dec_data_o <= double_c ? raw_d : fix_d;
    end
  end

  a_r3_enc_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (^enc_code_o) == 1'b0);

  a_r4_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o == $past(dec_valid_i));

  a_r10_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_single_o || dec_double_o) |-> dec_valid_o);

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_single_o && dec_double_o));

  a_r5_clean_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_i && !syn_nz && !ovp) |=> (!dec_single_o && !dec_double_o));

  a_r8_even_nonzero_is_double: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_i && syn_nz && !ovp) |=> (dec_double_o && !dec_single_o));

endmodule

// File: tb/secded_codec_tb.sv
`timescale 1ns/1ps
module secded_codec_tb_top;
  localparam int DW = 8;
  localparam int CW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [DW-1:0] enc_data_i = '0;
  logic [CW-1:0] enc_code_o;
  logic          dec_valid_i = 1'b0;
  logic [CW-1:0] dec_code_i = '0;
  logic          dec_valid_o, dec_single_o, dec_double_o;
  logic [DW-1:0] dec_data_o;

  secded_codec #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .enc_data_i(enc_data_i), .enc_code_o(enc_code_o),
    .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
    .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
    .dec_single_o(dec_single_o), .dec_double_o(dec_double_o)
  );

  logic [3:0] w4_enc_d = '0;
  logic [7:0] w4_enc_c;
  logic       w4_vi = 1'b0;
  logic [7:0] w4_code = '0;
  logic       w4_vo, w4_s, w4_dbl;
  logic [3:0] w4_d;

  secded_codec #(.DW(4)) dut_w4_i (
    .clk(clk), .rst_n(rst_n),
    .enc_data_i(w4_enc_d), .enc_code_o(w4_enc_c),
    .dec_valid_i(w4_vi), .dec_code_i(w4_code),
    .dec_valid_o(w4_vo), .dec_data_o(w4_d),
    .dec_single_o(w4_s), .dec_double_o(w4_dbl)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // data positions for DW=8 (R1)
  function automatic int dpos(input int j);
    int tbl[8] = '{3, 5, 6, 7, 9, 10, 11, 12};
    return tbl[j];
  endfunction

  function automatic logic [CW-1:0] ref_enc(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    c = '0;
    for (int j = 0; j < DW; j++) c[dpos(j) - 1] = d[j];
    for (int i = 0; i < 4; i++) begin
      logic p;
      p = 1'b0;
      for (int q = 1; q <= 12; q++) if (((q >> i) & 1) == 1) p ^= c[q - 1];
      c[(1 << i) - 1] = p;
    end
    c[12] = ^c[11:0];
    return c;
  endfunction

  function automatic logic [DW-1:0] ref_extract(input logic [CW-1:0] c);
    logic [DW-1:0] d;
    for (int j = 0; j < DW; j++) d[j] = c[dpos(j) - 1];
    return d;
  endfunction

  typedef struct {
    logic [DW-1:0] d;
    logic          s;
    logic          dbl;
    string         req;
  } exp_t;
  exp_t sb[$];

  task automatic send(input logic [CW-1:0] code, input logic [DW-1:0] d,
                      input logic s, input logic dbl, input string req);
    exp_t e;
    @(negedge clk);
    dec_valid_i = 1'b1;
    dec_code_i  = code;
    e.d = d; e.s = s; e.dbl = dbl; e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dec_valid_i = 1'b0;
      dec_code_i  = '0;
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (dec_valid_o) begin
          if (sb.size() == 0) begin
            chk(1'b0, "R4", "valid without pending word", 32'(dec_valid_o), 0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            chk(dec_data_o == e.d && dec_single_o == e.s && dec_double_o == e.dbl,
                e.req, "decode {data,single,double}",
                {22'd0, dec_data_o, dec_single_o, dec_double_o},
                {22'd0, e.d, e.s, e.dbl});
          end
        end else if (dec_single_o || dec_double_o) begin
          chk(1'b0, "R10", "flag while not valid",
              {30'd0, dec_single_o, dec_double_o}, 0);
        end
      end
    end
  end

  initial begin
    logic [CW-1:0] c;
    logic [7:0] vals[6] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h01, 8'h80};

    repeat (3) @(negedge clk);
    chk(dec_valid_o == 0 && dec_single_o == 0 && dec_double_o == 0, "R4",
        "reset outputs", {29'd0, dec_valid_o, dec_single_o, dec_double_o}, 0);
    rst_n = 1'b1;

    foreach (vals[k]) begin
      enc_data_i = vals[k];
      #1;
      chk(enc_code_o == ref_enc(vals[k]), "R1", "encoder layout/R2 check bits",
          32'(enc_code_o), 32'(ref_enc(vals[k])));
      chk((^enc_code_o) == 1'b0, "R3", "overall parity even",
          32'(^enc_code_o), 0);
    end

    foreach (vals[k]) send(ref_enc(vals[k]), vals[k], 1'b0, 1'b0, "R5");
    idle(2);

    for (int pos = 1; pos <= 12; pos++) begin
      c = ref_enc(8'h5A);
      c[pos - 1] = ~c[pos - 1];
      send(c, 8'h5A, 1'b1, 1'b0, "R6");
    end
    c = ref_enc(8'hC3);
    c[12] = ~c[12];
    send(c, 8'hC3, 1'b1, 1'b0, "R7");
    idle(1);

    c = ref_enc(8'h96);
    c[1] = ~c[1];
    c[6] = ~c[6];
    send(c, ref_extract(c), 1'b0, 1'b1, "R8");
    c = ref_enc(8'h0F);
    c[4] = ~c[4];
    c[10] = ~c[10];
    send(c, ref_extract(c), 1'b0, 1'b1, "R8");

    // positions 3,6,8 flipped: syndrome 13 > 12, odd parity
    c = ref_enc(8'h77);
    c[2] = ~c[2];
    c[5] = ~c[5];
    c[7] = ~c[7];
    send(c, ref_extract(c), 1'b0, 1'b1, "R9");
    idle(3);
    chk(sb.size() == 0, "R4", "scoreboard drained", 32'(sb.size()), 0);

    @(negedge clk);
    w4_vi = 1'b1;
    w4_code = 8'hBF;
    @(negedge clk);
    w4_vi = 1'b0;
    chk(w4_vo && w4_d == 4'hF && w4_s && !w4_dbl, "R11", "DW=4 syndrome 7 word",
        {24'd0, w4_vo, w4_d, w4_s, w4_dbl, 1'b0}, {24'd0, 1'b1, 4'hF, 1'b1, 1'b0, 1'b0});

    idle(2);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      chk(1'b0, "R4", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule